// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block copies a run of words from one memory region to another without processor involvement. Software writes a source word address, a destination word address, a word count, a block size and a style bit into a small register file, then sets a start bit. The engine asks a bus arbiter for mastership on a dedicated request/grant pair. Once granted, it alternates read and write beats on a simple master port, and each beat waits for the slave's ready signal.

In burst style the engine keeps the bus from the first word to the last. In cycle-stealing style it drops its request after every block of words. It then waits until the arbiter withdraws the grant, so the processor, the default master, gets bus cycles between blocks, and only after that does it request again. When the last word has been written and the bus has been handed back, a sticky done flag and the interrupt line rise. They stay high until software writes the status register.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, `br_req`, `m_valid` and `irq` are low and every register reads back as zero.
- R2: The register offsets on `cfg_addr` are 0 source address, 1 destination address, 2 word count, 3 block size, 4 control, 5 status. In control, bit 0 is a start strobe that reads back as 0, and bit 1 selects the style (0 burst, 1 cycle-stealing), which reads back as written. Status reads bit 0 as done and bit 1 as busy.
- R3: A start with a nonzero count raises `br_req` and holds it until `br_gnt` is seen. `m_valid` is never high unless both `br_req` and `br_gnt` are high.
- R4: Word i is read from source+i and then written to destination+i with the value read. Each beat holds its address until `m_ready`, and exactly count words are written.
- R5: In burst style the whole transfer uses a single grant.
- R6: In cycle-stealing style the request is dropped after each block of block-size words, and a block size of 0 acts as 1. While the grant is still high after a drop, the request stays low.
- R7: Done (status bit 0 and `irq`) rises after the last word once the grant has dropped. It stays set until any write to offset 5.
- R8: A start with a count of 0 sets done at once without raising `br_req`.
- R9: While busy, writes to offsets 0 to 4, a new start included, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt (sticky done) |
| br_req | output | 1 | Bus mastership request |
| br_gnt | input | 1 | Bus mastership grant |
| m_valid | output | 1 | Master beat valid |
| m_write | output | 1 | Beat is a write (0 = read) |
| m_addr | output | AW (16) | Beat word address |
| m_wdata | output | DW (32) | Write data |
| m_rdata | input | DW (32) | Read data, valid with m_ready |
| m_ready | input | 1 | Slave completes the beat |

## Verification
A wrong count or block counter shows up at the ports as the wrong number of grant episodes or a stray write just past the destination region. Both are visible as soon as the transfer ends. A corrupted address step puts a wrong value into the destination word on the very next write beat. A faulty request/grant sequence either makes `br_req` rise while the grant is still high, or makes `m_valid` appear without a grant, within one cycle of the bad transition. A broken done flag shows as `irq` either missing after the final release or vanishing without a status write.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int unsigned CFG_W = 32;
  localparam logic [2:0] OFS_SRC  = 3'd0;
  localparam logic [2:0] OFS_DST  = 3'd1;
  localparam logic [2:0] OFS_LEN  = 3'd2;
  localparam logic [2:0] OFS_BLK  = 3'd3;
  localparam logic [2:0] OFS_CTRL = 3'd4;
  localparam logic [2:0] OFS_STAT = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_RD,
    ST_WR
  } dma_state_e;
endpackage

// File: rtl/dma_regs.sv
`timescale 1ns/1ps
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             busy,
  input  logic             done_set,
  output logic             start_o,
  output logic             steal_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [LW-1:0]    len_o,
  output logic [LW-1:0]    blk_o,
  output logic             irq_o
);
  logic done_q;
  logic cfg_ok;

  assign cfg_ok  = cfg_we && !busy;
  assign start_o = cfg_ok && (cfg_addr == OFS_CTRL) && cfg_wdata[0];
  assign irq_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o   <= '0;
      dst_o   <= '0;
      len_o   <= '0;
      blk_o   <= '0;
      steal_o <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cfg_ok) begin
        case (cfg_addr)
          OFS_SRC:  src_o   <= cfg_wdata[AW-1:0];
          OFS_DST:  dst_o   <= cfg_wdata[AW-1:0];
          OFS_LEN:  len_o   <= cfg_wdata[LW-1:0];
          OFS_BLK:  blk_o   <= cfg_wdata[LW-1:0];
          OFS_CTRL: steal_o <= cfg_wdata[1];
          default:  ;
        endcase
      end
      if (cfg_we && (cfg_addr == OFS_STAT)) done_q <= 1'b0;
      if (done_set) done_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_SRC:  cfg_rdata[AW-1:0] = src_o;
      OFS_DST:  cfg_rdata[AW-1:0] = dst_o;
      OFS_LEN:  cfg_rdata[LW-1:0] = len_o;
      OFS_BLK:  cfg_rdata[LW-1:0] = blk_o;
      OFS_CTRL: cfg_rdata[1]      = steal_o;
      OFS_STAT: cfg_rdata[1:0]    = {busy, done_q};
      default:  cfg_rdata         = '0;
    endcase
  end
endmodule

// File: rtl/dma_cnt.sv
`timescale 1ns/1ps
module dma_cnt #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [LW-1:0] len_in,
  input  logic [LW-1:0] blk_in,
  input  logic          blk_reload,
  input  logic          word_done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic          rem_last,
  output logic          rem_zero,
  output logic          blk_last
);
  logic [LW-1:0] rem_q;
  logic [LW-1:0] blk_q;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [LW-1:0] blk_size(input logic [LW-1:0] b);
    return (b == '0) ? LW'(1) : b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
      blk_q <= '0;
    end else if (load) begin
      src_q <= src_in;
      dst_q <= dst_in;
      rem_q <= len_in;
      blk_q <= blk_size(blk_in);
    end else begin
      if (blk_reload) begin
        blk_q <= blk_size(blk_in);
      end else if (word_done) begin
        blk_q <= blk_q - LW'(1);
      end
      if (word_done) begin
        src_q <= addr_step(src_q);
        dst_q <= addr_step(dst_q);
        rem_q <= rem_q - LW'(1);
      end
    end
  end

  assign rem_last = (rem_q == LW'(1));
  assign rem_zero = (rem_q == '0);
  assign blk_last = (blk_q == LW'(1));
endmodule

// File: rtl/dma_fsm.sv
`timescale 1ns/1ps
module dma_fsm
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          len_zero,
  input  logic          steal,
  input  logic          br_gnt,
  input  logic          m_ready,
  input  logic [DW-1:0] m_rdata,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] dst_q,
  input  logic          rem_last,
  input  logic          rem_zero,
  input  logic          blk_last,
  output logic          br_req,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  output logic          busy,
  output logic          done_set,
  output logic          load,
  output logic          grant_take,
  output logic          word_done
);
  dma_state_e st_q, st_d;
  logic [DW-1:0] hold_q;

  assign busy       = (st_q != ST_IDLE);
  assign br_req     = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
  assign m_valid    = (st_q == ST_RD) || (st_q == ST_WR);
  assign m_write    = (st_q == ST_WR);
  assign m_addr     = m_write ? dst_q : src_q;
  assign m_wdata    = hold_q;
  assign load       = (st_q == ST_IDLE) && start && !len_zero;
  assign grant_take = (st_q == ST_REQ) && br_gnt;
  assign word_done  = (st_q == ST_WR) && m_ready;
  assign done_set   = ((st_q == ST_IDLE) && start && len_zero) ||
                      ((st_q == ST_WAIT) && !br_gnt && rem_zero);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start && !len_zero) st_d = ST_WAIT;
      ST_WAIT: if (!br_gnt) st_d = rem_zero ? ST_IDLE : ST_REQ;
      ST_REQ:  if (br_gnt) st_d = ST_RD;
      ST_RD:   if (m_ready) st_d = ST_WR;
      ST_WR: begin
        if (m_ready) begin
          if (rem_last || (steal && blk_last)) st_d = ST_WAIT;
          else st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == ST_RD) && m_ready) hold_q <= m_rdata;
    end
  end
endmodule

// File: rtl/dma_steal_ctrl.sv
`timescale 1ns/1ps
module dma_steal_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             irq,
  output logic             br_req,
  input  logic             br_gnt,
  output logic             m_valid,
  output logic             m_write,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  input  logic [DW-1:0]    m_rdata,
  input  logic             m_ready
);
  logic          start, steal, busy, done_set, load, grant_take, word_done;
  logic [AW-1:0] src_cfg, dst_cfg, src_q, dst_q;
  logic [LW-1:0] len_cfg, blk_cfg;
  logic          rem_last, rem_zero, blk_last;

  dma_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .done_set(done_set), .start_o(start), .steal_o(steal),
    .src_o(src_cfg), .dst_o(dst_cfg), .len_o(len_cfg), .blk_o(blk_cfg),
    .irq_o(irq)
  );

  dma_cnt #(.AW(AW), .LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .src_in(src_cfg),
    .dst_in(dst_cfg), .len_in(len_cfg), .blk_in(blk_cfg),
    .blk_reload(grant_take), .word_done(word_done), .src_q(src_q),
    .dst_q(dst_q), .rem_last(rem_last), .rem_zero(rem_zero),
    .blk_last(blk_last)
  );

  dma_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .len_zero(len_cfg == '0),
    .steal(steal), .br_gnt(br_gnt), .m_ready(m_ready), .m_rdata(m_rdata),
    .src_q(src_q), .dst_q(dst_q), .rem_last(rem_last), .rem_zero(rem_zero),
    .blk_last(blk_last), .br_req(br_req), .m_valid(m_valid),
    .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .busy(busy),
    .done_set(done_set), .load(load), .grant_take(grant_take),
    .word_done(word_done)
  );
endmodule

// File: rtl/dma_steal_chk.sv
`timescale 1ns/1ps
module dma_steal_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_req,
  input logic          br_gnt,
  input logic          m_valid,
  input logic          m_write,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic          irq,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic          done_set,
  input logic          busy,
  input logic          word_done
);
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && !br_gnt) |=> br_req);

  a_r3_valid_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (br_req && br_gnt));

  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_write && m_ready) |=> (m_valid && m_write));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  a_r6_no_rerequest_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && br_gnt) |=> !br_req);

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && cfg_addr == 3'd5)) |=> irq);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> (!busy && irq));

  a_r4_word_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (m_valid && m_write && m_ready));
endmodule

bind dma_steal_ctrl dma_steal_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_gnt(br_gnt),
  .m_valid(m_valid), .m_write(m_write), .m_ready(m_ready), .m_addr(m_addr),
  .irq(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .done_set(done_set),
  .busy(busy), .word_done(word_done)
);

// File: tb/dma_steal_ctrl_bench.sv
`timescale 1ns/1ps
module dma_steal_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, br_req, m_valid, m_write;
  logic        br_gnt = 1'b0;
  logic [15:0] m_addr;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;
  logic        m_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem [0:255];
  logic        wr_seen [0:255];
  logic        gnt_d1 = 1'b0, gnt_q = 1'b0, req_q = 1'b0;
  int          grants = 0, reqs = 0, wait_cnt = 0;

  always #2 clk = ~clk;

  dma_steal_ctrl u_dma_steal_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .br_req(br_req), .br_gnt(br_gnt), .m_valid(m_valid),
    .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready)
  );

  function automatic logic [31:0] pat(input int a);
    return 32'hC0DE_0000 ^ (a * 32'h0000_0101);
  endfunction

  // Arbiter: grant two cycles after a request, dropped one cycle after release.
  always @(posedge clk) begin
    if (!rst_n) begin
      gnt_d1 <= 1'b0; br_gnt <= 1'b0; gnt_q <= 1'b0; req_q <= 1'b0;
    end else begin
      gnt_d1 <= br_req;
      br_gnt <= br_req & gnt_d1;
      gnt_q  <= br_gnt;
      req_q  <= br_req;
      if (br_gnt && !gnt_q) grants <= grants + 1;
      if (br_req && !req_q) reqs <= reqs + 1;
    end
  end

  // Slave: ready after addr[1:0] wait cycles; unwritten words read a pattern.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready <= 1'b0; wait_cnt <= 0;
      for (int i = 0; i < 256; i++) wr_seen[i] <= 1'b0;
    end else if (m_ready) begin
      m_ready <= 1'b0; wait_cnt <= 0;
    end else if (m_valid) begin
      if (wait_cnt == int'(m_addr[1:0])) begin
        m_ready <= 1'b1;
        if (m_write) begin
          mem[m_addr[7:0]] <= m_wdata;
          wr_seen[m_addr[7:0]] <= 1'b1;
        end else begin
          m_rdata <= wr_seen[m_addr[7:0]] ? mem[m_addr[7:0]] : pat(int'(m_addr[7:0]));
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(irq === 1'b1, req, {31'd0, irq}, 32'd1);
  endtask

  task automatic program_run(input int src, input int dst, input int len,
                             input int blk, input bit steal);
    wr_reg(3'd0, src);
    wr_reg(3'd1, dst);
    wr_reg(3'd2, len);
    wr_reg(3'd3, blk);
    wr_reg(3'd4, {30'd0, steal, 1'b1});
  endtask

  task automatic check_copy(input int src, input int dst, input int len,
                            input string req);
    for (int i = 0; i < len; i++)
      check(wr_seen[dst+i] && mem[dst+i] == pat(src+i), req, mem[dst+i], pat(src+i));
    check(wr_seen[dst+len] == 1'b0, {req, " extra word"}, {31'd0, wr_seen[dst+len]}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(irq == 1'b0 && br_req == 1'b0 && m_valid == 1'b0, "R1 outputs",
          {29'd0, irq, br_req, m_valid}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), d);
      check(d == 32'd0, "R1 register", d, 32'd0);
    end
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, d);
    check(d == 32'h2, "R2 style readback", d, 32'h2);
    wr_reg(3'd3, 32'h5);
    rd_reg(3'd3, d);
    check(d == 32'h5, "R2 block readback", d, 32'h5);
    rd_reg(3'd5, d);
    check(d == 32'h0, "R2 status idle", d, 32'h0);
  endtask

  task automatic t_burst;
    int g0 = grants;
    logic [31:0] d;
    program_run(16, 64, 5, 2, 1'b0);
    wait_irq("R7 burst done");
    rd_reg(3'd5, d);
    check(d == 32'h1, "R7 status done", d, 32'h1);
    check_copy(16, 64, 5, "R4 burst copy");
    check(grants - g0 == 1, "R5 one grant", grants - g0, 1);
    wr_reg(3'd5, 0);
  endtask

  task automatic t_steal;
    int g0 = grants;
    program_run(32, 96, 7, 3, 1'b1);
    wait_irq("R7 steal done");
    check_copy(32, 96, 7, "R4 steal copy");
    check(grants - g0 == 3, "R6 steal grants", grants - g0, 3);
    wr_reg(3'd5, 0);
  endtask

  task automatic t_blk0;
    int g0 = grants;
    program_run(48, 128, 3, 0, 1'b1);
    wait_irq("R6 blk0 done");
    check_copy(48, 128, 3, "R6 blk0 copy");
    check(grants - g0 == 3, "R6 blk0 grants", grants - g0, 3);
    wr_reg(3'd5, 0);
  endtask

  task automatic t_len0;
    int r0 = reqs;
    program_run(0, 200, 0, 1, 1'b0);
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R8 immediate done", {31'd0, irq}, 32'd1);
    repeat (10) @(negedge clk);
    check(reqs == r0, "R8 no request", reqs - r0, 0);
    check(wr_seen[200] == 1'b0, "R8 no write", {31'd0, wr_seen[200]}, 32'd0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    repeat (20) @(negedge clk);
    check(irq == 1'b1, "R7 sticky", {31'd0, irq}, 32'd1);
    wr_reg(3'd5, 0);
    rd_reg(3'd5, d);
    check(irq == 1'b0 && d == 32'h0, "R7 cleared", d, 32'h0);
  endtask

  task automatic t_busy;
    int g0 = grants;
    logic [31:0] d;
    program_run(16, 160, 6, 6, 1'b0);
    rd_reg(3'd5, d);
    check(d[1] == 1'b1, "R9 busy flag", d, 32'h2);
    wr_reg(3'd2, 9);
    wr_reg(3'd1, 220);
    wr_reg(3'd4, 32'h3);
    rd_reg(3'd2, d);
    check(d == 32'd6, "R9 len kept", d, 32'd6);
    rd_reg(3'd4, d);
    check(d == 32'h0, "R9 ctrl kept", d, 32'h0);
    wait_irq("R9 done");
    wr_reg(3'd5, 0);
    repeat (40) @(negedge clk);
    check(grants - g0 == 1 && irq == 1'b0, "R9 second start ignored", grants - g0, 1);
    check_copy(16, 160, 6, "R9 copy");
    check(wr_seen[220] == 1'b0, "R9 dst kept", {31'd0, wr_seen[220]}, 32'd0);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_burst();
    t_steal();
    t_blk0();
    t_len0();
    t_sticky();
    t_busy();
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule